// File: doc/BRIEF.md
# Redundant Reference Selection Controller

This block decides which of two timing references, a primary and a backup, feeds a downstream phase-locked loop, and when that loop must coast on its own in holdover. It watches one loss-of-signal flag for each reference. Both flags may arrive from any clock domain, so each is resynchronised before it is used. In automatic operation a loss of the primary alone first puts the loop into holdover. During a programmable guard interval, counted in clock ticks, the primary has a chance to come back. Only once that interval has run out without the primary recovering does the controller move to the backup. It returns to the primary as soon as the primary's flag clears.

A mode input overrides the automatic behaviour. In manual operation a separate select input picks the reference outright, and the loss flags have no effect. When both references are lost, the controller asks for holdover and stays there until either reference is usable again. Both outputs are registered.

Top module: `refsel_ctrl`

## Requirements
- R1: After synchronous reset the controller is in primary-normal: ref_sel = 0 (0 means primary, 1 means secondary) and holdover = 0.
- R2: With man_mode = 1 the controller follows man_ref (0 gives primary, 1 gives secondary), holds holdover at 0 and ignores both loss flags; with man_mode = 0 selection is automatic.
- R3: Each loss flag passes through two synchroniser flops, so an output reacts on the third rising edge after a flag changes.
- R4: In automatic mode, seeing pri_los = 1 with sec_los = 0 while in primary-normal puts the controller into primary-holdover on the next decision: holdover = 1, ref_sel = 0.
- R5: Primary-holdover lasts guard_ticks + 1 cycles, with guard_ticks sampled on entry. If the primary is still lost at the end of that time, the controller moves to secondary-normal (ref_sel = 1, holdover = 0), and the internal expiry is a single-cycle pulse.
- R6: If pri_los clears during primary-holdover, the controller returns to primary-normal and never selects the secondary for that loss event.
- R7: In secondary-normal, a cleared pri_los returns the controller to primary-normal.
- R8: With both flags high, the controller enters all-holdover (holdover = 1, ref_sel = 0) from any automatic state. It leaves when a reference returns: to primary-normal if pri_los clears, otherwise to secondary-normal if only sec_los clears.
- R9: ref_sel and holdover are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_los | input | 1 | Primary reference lost (asynchronous) |
| sec_los | input | 1 | Secondary reference lost (asynchronous) |
| man_mode | input | 1 | 1 = manual selection, 0 = automatic |
| man_ref | input | 1 | Manual choice: 0 primary, 1 secondary |
| guard_ticks | input | 16 | Guard interval length in clock ticks |
| ref_sel | output | 1 | Selected reference: 0 primary, 1 secondary |
| holdover | output | 1 | PLL holdover command |

## Verification
The assertions take the synchronised loss flags as the state machine's inputs. They also take man_mode and man_ref to be quasi-static control levels that are sampled directly on the clock, and they assume guard_ticks stays steady while a guard interval is running. The stimulus changes every input just after a falling edge. It leaves guard_ticks alone except between loss events, and it switches modes only while the loss flags are stable. A deliberate one-cycle glitch on the primary flag exercises the synchroniser path within those rules.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    localparam int GUARD_W    = 16;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        ST_PRI_RUN  = 2'b00,
        ST_PRI_HOLD = 2'b01,
        ST_SEC_RUN  = 2'b10,
        ST_ALL_HOLD = 2'b11
    } sel_state_t;

    typedef struct packed {
        logic pri;
        logic sec;
    } los_pair_t;

    function automatic logic st_is_hold(sel_state_t s);
        return (s == ST_PRI_HOLD) || (s == ST_ALL_HOLD);
    endfunction

    function automatic logic st_is_sec(sel_state_t s);
        return (s == ST_SEC_RUN);
    endfunction

endpackage

// File: rtl/refsel_sync.sv
module refsel_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[g] <= '0;
                    else     pipe_q[g] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) pipe_q[g] <= '0;
                    else     pipe_q[g] <= pipe_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/refsel_guard_timer.sv
module refsel_guard_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          active,
    input  logic [CW-1:0] ticks,
    output logic          expire
);
    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= ticks;
            run_q <= 1'b1;
        end else if (!active) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = run_q && active && (cnt_q == '0);
endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
    import refsel_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       man_mode,
    input  logic       man_ref,
    input  los_pair_t  los,
    input  logic       guard_expire,
    output sel_state_t st_q,
    output logic       enter_hold,
    output logic       ref_sel_q,
    output logic       hold_q
);
    sel_state_t st_nxt;

    always_comb begin
        st_nxt = st_q;
        if (man_mode) begin
            st_nxt = man_ref ? ST_SEC_RUN : ST_PRI_RUN;
        end else begin
            unique case (st_q)
                ST_PRI_RUN: begin
                    if (los.pri && los.sec)  st_nxt = ST_ALL_HOLD;
                    else if (los.pri)        st_nxt = ST_PRI_HOLD;
                end
                ST_PRI_HOLD: begin
                    if (!los.pri)            st_nxt = ST_PRI_RUN;
                    else if (los.sec)        st_nxt = ST_ALL_HOLD;
                    else if (guard_expire)   st_nxt = ST_SEC_RUN;
                end
                ST_SEC_RUN: begin
                    if (!los.pri)            st_nxt = ST_PRI_RUN;
                    else if (los.sec)        st_nxt = ST_ALL_HOLD;
                end
                ST_ALL_HOLD: begin
                    if (!los.pri)            st_nxt = ST_PRI_RUN;
                    else if (!los.sec)       st_nxt = ST_SEC_RUN;
                end
                default:                     st_nxt = ST_PRI_RUN;
            endcase
        end
    end

    assign enter_hold = (st_nxt == ST_PRI_HOLD) && (st_q != ST_PRI_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_PRI_RUN;
            ref_sel_q <= 1'b0;
            hold_q    <= 1'b0;
        end else begin
            st_q      <= st_nxt;
            ref_sel_q <= st_is_sec(st_nxt);
            hold_q    <= st_is_hold(st_nxt);
        end
    end
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
    import refsel_pkg::*;
#(
    parameter int GW = GUARD_W,
    parameter int SD = SYNC_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pri_los,
    input  logic          sec_los,
    input  logic          man_mode,
    input  logic          man_ref,
    input  logic [GW-1:0] guard_ticks,
    output logic          ref_sel,
    output logic          holdover
);
    localparam int NFLAGS = $bits(los_pair_t);

    los_pair_t  los_raw;
    los_pair_t  los_s;
    sel_state_t st_cur;
    logic       guard_expire;
    logic       enter_hold;
    logic       in_pri_hold;

    assign los_raw.pri = pri_los;
    assign los_raw.sec = sec_los;

    refsel_sync #(.WIDTH(NFLAGS), .STAGES(SD)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (los_raw),
        .dout (los_s)
    );

    assign in_pri_hold = (st_cur == ST_PRI_HOLD);

    refsel_guard_timer #(.CW(GW)) u_guard (
        .clk    (clk),
        .rst    (rst),
        .load   (enter_hold),
        .active (in_pri_hold),
        .ticks  (guard_ticks),
        .expire (guard_expire)
    );

    refsel_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .man_mode     (man_mode),
        .man_ref      (man_ref),
        .los          (los_s),
        .guard_expire (guard_expire),
        .st_q         (st_cur),
        .enter_hold   (enter_hold),
        .ref_sel_q    (ref_sel),
        .hold_q       (holdover)
    );
endmodule

// File: rtl/refsel_ctrl_chk.sv
module refsel_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       man_mode,
    input logic       man_ref,
    input logic       p_s,
    input logic       s_s,
    input logic [1:0] st,
    input logic       expire,
    input logic       ref_sel,
    input logic       holdover
);
    a_r4_enter_hold: assert property (@(posedge clk) disable iff (rst)
        (!man_mode && st == 2'b00 && p_s && !s_s) |=> (holdover && !ref_sel));

    a_r6_recover_in_guard: assert property (@(posedge clk) disable iff (rst)
        (!man_mode && st == 2'b01 && !p_s) |=> (!holdover && !ref_sel));

    a_r7_revert_primary: assert property (@(posedge clk) disable iff (rst)
        (!man_mode && st == 2'b10 && !p_s) |=> (!ref_sel && !holdover));

    a_r8_both_lost: assert property (@(posedge clk) disable iff (rst)
        (!man_mode && p_s && s_s) |=> (holdover && !ref_sel));

    a_r5_expire_pulse: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

    a_r5_expire_to_sec: assert property (@(posedge clk) disable iff (rst)
        (!man_mode && expire && p_s && !s_s) |=> (ref_sel && !holdover));

    a_r2_manual_follow: assert property (@(posedge clk) disable iff (rst)
        man_mode |=> (!holdover && ref_sel == $past(man_ref)));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ref_sel && holdover));
endmodule

bind refsel_ctrl refsel_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .man_mode (man_mode),
    .man_ref  (man_ref),
    .p_s      (los_s.pri),
    .s_s      (los_s.sec),
    .st       (st_cur),
    .expire   (guard_expire),
    .ref_sel  (ref_sel),
    .holdover (holdover)
);

// File: tb/test_refsel_ctrl.sv
module test_refsel_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pri_los = 1'b0;
    logic        sec_los = 1'b0;
    logic        man_mode = 1'b0;
    logic        man_ref = 1'b0;
    logic [15:0] guard_ticks = 16'd5;
    logic        ref_sel;
    logic        holdover;

    always #10 clk = ~clk;

    refsel_ctrl i_refsel_ctrl (
        .clk         (clk),
        .rst         (rst),
        .pri_los     (pri_los),
        .sec_los     (sec_los),
        .man_mode    (man_mode),
        .man_ref     (man_ref),
        .guard_ticks (guard_ticks),
        .ref_sel     (ref_sel),
        .holdover    (holdover)
    );

    int    n_cmp  = 0;
    int    n_bad  = 0;
    int    cycles = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // behavioural model: mode 0 primary, 1 primary hold, 2 secondary, 3 all hold
    int m_mode = 0;
    int m_held = 0;
    int m_guard = 0;
    bit qp[$];
    bit qs[$];

    initial begin
        qp = '{0, 0};
        qs = '{0, 0};
    end

    always @(posedge clk) begin
        bit p, s;
        cycles++;
        if (rst) begin
            qp = '{0, 0};
            qs = '{0, 0};
            m_mode = 0;
        end else begin
            p = qp.pop_front();
            s = qs.pop_front();
            qp.push_back(pri_los);
            qs.push_back(sec_los);
            if (man_mode) begin
                m_mode = man_ref ? 2 : 0;
            end else if (!p) begin
                m_mode = 0;
            end else if (s) begin
                m_mode = 3;
            end else begin
                case (m_mode)
                    0: begin m_mode = 1; m_held = 0; m_guard = guard_ticks; end
                    1: if (m_held == m_guard) m_mode = 2; else m_held++;
                    3: m_mode = 2;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        bit es, eh;
        if (!rst && !done) begin
            es = (m_mode == 2);
            eh = (m_mode == 1) || (m_mode == 3);
            n_cmp++;
            if (ref_sel !== es || holdover !== eh) begin
                n_bad++;
                $display("FAIL %s cycle %0d: ref_sel/holdover = %b/%b, expected %b/%b",
                         cur_req, cycles, ref_sel, holdover, es, eh);
            end
            n_cmp++;
            if (ref_sel === 1'b1 && holdover === 1'b1) begin
                n_bad++;
                $display("FAIL R9 cycle %0d: ref_sel/holdover = 1/1, expected not both 1", cycles);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        wait (cycles > 150000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        cur_req = "R1";
        wait_cyc(4);
        // R4 then R6: short primary loss recovers inside the guard window
        cur_req = "R4";
        pri_los = 1'b1;
        wait_cyc(4);
        cur_req = "R6";
        pri_los = 1'b0;
        wait_cyc(6);
        // R3: one-cycle glitch still travels the synchroniser
        cur_req = "R3";
        pri_los = 1'b1;
        wait_cyc(1);
        pri_los = 1'b0;
        wait_cyc(6);
        // R5: long loss, failover after guard interval
        cur_req = "R5";
        pri_los = 1'b1;
        wait_cyc(20);
        // R7: primary returns
        cur_req = "R7";
        pri_los = 1'b0;
        wait_cyc(6);
        // R8: both lost from primary, secondary returns, then primary
        cur_req = "R8";
        pri_los = 1'b1;
        sec_los = 1'b1;
        wait_cyc(10);
        sec_los = 1'b0;
        wait_cyc(6);
        sec_los = 1'b1;
        wait_cyc(6);
        pri_los = 1'b0;
        wait_cyc(6);
        sec_los = 1'b0;
        wait_cyc(4);
        // R5 with zero guard interval
        cur_req = "R5";
        guard_ticks = 16'd0;
        pri_los = 1'b1;
        wait_cyc(8);
        // R8: secondary lost while on the secondary
        cur_req = "R8";
        sec_los = 1'b1;
        wait_cyc(6);
        pri_los = 1'b0;
        sec_los = 1'b0;
        wait_cyc(6);
        // R5: loss interrupted by secondary loss inside guard
        cur_req = "R5";
        guard_ticks = 16'd9;
        pri_los = 1'b1;
        wait_cyc(6);
        sec_los = 1'b1;
        wait_cyc(5);
        sec_los = 1'b0;
        wait_cyc(6);
        pri_los = 1'b0;
        wait_cyc(6);
        // R2: manual selection ignores loss flags
        cur_req = "R2";
        man_mode = 1'b1;
        man_ref = 1'b1;
        wait_cyc(3);
        pri_los = 1'b1;
        sec_los = 1'b1;
        wait_cyc(8);
        man_ref = 1'b0;
        wait_cyc(5);
        sec_los = 1'b0;
        wait_cyc(5);
        pri_los = 1'b0;
        wait_cyc(4);
        man_mode = 1'b0;
        wait_cyc(4);
        // R1: reset in the middle of holdover
        cur_req = "R1";
        pri_los = 1'b1;
        wait_cyc(5);
        rst = 1'b1;
        pri_los = 1'b0;
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(5);
        finish_run();
    end
endmodule